// File: doc/BRIEF.md
# 1-Wire transaction sequencer

This block drives a single 1-Wire transaction through an external bit-slot timing engine. Before a transaction, software-side logic fills two command buffers: one with ROM-level command bytes and one with transport-level command bytes. It then presents four lengths and two mode flags and pulses `start_i`. The sequencer first issues a bus reset and checks the presence answer. It then walks the phases in a fixed order: ROM bytes written, ROM bytes read, transport bytes written, transport data read. It issues exactly one slot request per bit.

Each slot request is a held level on `slot_req_o` that carries an opcode and a speed select, and the timing engine acknowledges it with a one-cycle `slot_done_i`. Received bits are packed into two receive buffers, one for the ROM phase and one for the transport phase. These buffers can be read back through a combinational port. At the end, a one-cycle `done_o` comes with a two-bit status. The reset slot and the ROM phase always run at regular speed. The transport phase can switch to overdrive speed, and its read can be counted in bits instead of bytes.

Top module: `owt_txn_seq`

## Requirements
- R1: When the presence answer is "nobody" (`slot_pres_i`=1), the reset slot is repeated up to 4 more times. After 5 such answers in a row, the transaction ends with status 1 (no device) and no other slot is issued.
- R2: A presence answer of 2 or 3 (wiring fault) ends the transaction in the next cycle with status 2, and no further slot is issued.
- R3: After a good presence answer (0), slots follow the order ROM write, ROM read, transport write, transport read. Phases of zero length are skipped. Command bytes are sent least-significant bit first, with opcode 2 for a one bit and opcode 1 for a zero bit.
- R4: Each read slot uses opcode 3. Read bytes are assembled least-significant bit first. Byte k of a read phase lands at address k of that phase's receive buffer (`rsp_sel_i`=0 for ROM, 1 for transport).
- R5: The reset slot (opcode 0) and every ROM-phase slot carry `slot_od_o`=0.
- R6: Transport-phase slots carry `slot_od_o` equal to the overdrive flag that was sampled at start.
- R7: When the transport command length is zero, neither transport writes nor transport reads are issued, whatever the transport read length is.
- R8: With the bit-read flag set, the transport read length counts single read slots. Bit i lands in bit i%8 of byte i/8. Unused upper bits of the last byte read back as 0.
- R9: `done_o` is a single-cycle pulse, followed by idle (`busy_o`=0). Status 0 means success. After reset, the block is idle with status 0 and no request.
- R10: A length above the buffer size is clamped to the buffer size. This is BUF_BYTES bytes, or BUF_BYTES*8 bits for a bit-counted read.
- R11: A `start_i` pulse while `busy_o` is high has no effect. No extra transaction follows the current one.
- R12: While `slot_req_o` is high and `slot_done_i` is low, the opcode and the speed select stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transaction (taken only when idle) |
| rom_len_i | input | LEN_W | ROM command byte count |
| rom_rd_len_i | input | LEN_W | ROM read byte count |
| xpt_len_i | input | LEN_W | Transport command byte count |
| xpt_rd_len_i | input | LEN_W | Transport read count (bytes, or bits when bit_read_i) |
| overdrive_i | input | 1 | Transport phase at overdrive speed |
| bit_read_i | input | 1 | Transport read counted in bits |
| cmd_we_i | input | 1 | Command buffer write strobe |
| cmd_sel_i | input | 1 | Command buffer select: 0 ROM, 1 transport |
| cmd_addr_i | input | AW | Command buffer write address |
| cmd_data_i | input | 8 | Command buffer write data |
| rsp_sel_i | input | 1 | Receive buffer select: 0 ROM, 1 transport |
| rsp_addr_i | input | AW | Receive buffer read address |
| rsp_data_o | output | 8 | Receive buffer read data |
| slot_req_o | output | 1 | Slot request, held until acknowledged |
| slot_op_o | output | 2 | Slot opcode: 0 reset, 1 write 0, 2 write 1, 3 read |
| slot_od_o | output | 1 | Slot speed: 1 overdrive |
| slot_done_i | input | 1 | Slot acknowledge, one cycle |
| slot_bit_i | input | 1 | Bit sampled by a read slot |
| slot_pres_i | input | 2 | Presence answer of a reset slot: 0 present, 1 none, 2/3 fault |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction finished, one cycle |
| status_o | output | 2 | 0 ok, 1 no device, 2 wiring fault |

## Verification
The assertions assume that the timing engine raises `slot_done_i` for only one cycle, and only while a request is pending. They also assume that `slot_pres_i` and `slot_bit_i` are valid in that cycle, and that the command buffers are not written while `busy_o` is high. The bench stimulus keeps to these rules. Its bus model acknowledges a held request after a fixed delay and pulls presence answers and read bits from prepared lists. All buffer loads happen while the block is idle. The only deliberate violation is a `start_i` pulse during a busy transaction, which is checked to have no effect.

// File: rtl/owt_pkg.sv
package owt_pkg;
  typedef enum logic [1:0] {OP_RST = 2'd0, OP_W0 = 2'd1, OP_W1 = 2'd2, OP_RD = 2'd3} slot_op_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_NODEV = 2'd1, ST_FAULT = 2'd2} txn_status_e;
  typedef enum logic [2:0] {PH_RST = 3'd0, PH_ROMW = 3'd1, PH_ROMR = 3'd2,
                            PH_XW = 3'd3, PH_XR = 3'd4} phase_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_SLOT = 2'd1, S_FIN = 2'd2} seq_state_e;
  localparam logic [1:0] PR_OK   = 2'd0;
  localparam logic [1:0] PR_NONE = 2'd1;
endpackage

// File: rtl/owt_byte_ram.sv
module owt_byte_ram #(
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/owt_seq_ctl.sv
module owt_seq_ctl
  import owt_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 8,
  parameter int RETRIES   = 4,
  parameter int AW        = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] rom_len_i,
  input  logic [LEN_W-1:0] rom_rd_len_i,
  input  logic [LEN_W-1:0] xpt_len_i,
  input  logic [LEN_W-1:0] xpt_rd_len_i,
  input  logic             overdrive_i,
  input  logic             bit_read_i,
  output logic             cmd_sel_o,
  output logic [AW-1:0]    cmd_raddr_o,
  input  logic [7:0]       cmd_rdata_i,
  output logic             rx_we_o,
  output logic             rx_sel_o,
  output logic [AW-1:0]    rx_waddr_o,
  output logic [7:0]       rx_wdata_o,
  output logic             slot_req_o,
  output logic [1:0]       slot_op_o,
  output logic             slot_od_o,
  input  logic             slot_done_i,
  input  logic             slot_bit_i,
  input  logic [1:0]       slot_pres_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  localparam int MAXBITS = BUF_BYTES * 8;
  localparam int CNT_W   = $clog2(MAXBITS + 1);
  localparam int TRY_W   = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1;

  function automatic logic [CNT_W-1:0] clamp_len(input logic [LEN_W-1:0] v, input int unsigned lim);
    logic [31:0] w;
    w = 32'(v);
    if (w > lim) w = lim;
    return CNT_W'(w);
  endfunction

  function automatic logic [CNT_W-1:0] to_slots(input logic [CNT_W-1:0] nbytes);
    return CNT_W'({nbytes, 3'b000});
  endfunction

  seq_state_e        state_q;
  phase_e            phase_q, nxt_ph;
  logic [CNT_W-1:0]  cnt_q;
  logic [TRY_W-1:0]  tries_q;
  logic              od_q;
  logic [7:0]        sh_q, sh_nxt;
  logic [CNT_W-1:0]  n_romw_q, n_romr_q, n_xw_q, n_xr_q;
  logic [1:0]        status_q;
  logic [CNT_W-1:0]  tot [8];
  logic [CNT_W-1:0]  cur_tot;
  logic [2:0]        bit_idx;
  logic              last, is_rd, is_wr, nxt_any, hs;

  always_comb begin
    for (int k = 0; k < 8; k++) tot[k] = '0;
    tot[PH_ROMW] = n_romw_q;
    tot[PH_ROMR] = n_romr_q;
    tot[PH_XW]   = n_xw_q;
    tot[PH_XR]   = n_xr_q;
  end

  assign cur_tot = tot[phase_q];
  assign bit_idx = cnt_q[2:0];
  assign last    = (CNT_W'(cnt_q + 1'b1) == cur_tot);
  assign is_rd   = (phase_q == PH_ROMR) || (phase_q == PH_XR);
  assign is_wr   = (phase_q == PH_ROMW) || (phase_q == PH_XW);
  assign hs      = (state_q == S_SLOT) && slot_done_i;

  // first non-empty phase after the current one
  always_comb begin
    nxt_ph  = PH_RST;
    nxt_any = 1'b0;
    for (int k = 4; k >= 1; k--) begin
      if (k > int'(phase_q) && tot[k] != '0) begin
        nxt_ph  = phase_e'(k);
        nxt_any = 1'b1;
      end
    end
  end

  always_comb begin
    sh_nxt          = sh_q;
    sh_nxt[bit_idx] = slot_bit_i;
  end

  always_comb begin
    if (phase_q == PH_RST)  slot_op_o = OP_RST;
    else if (is_rd)         slot_op_o = OP_RD;
    else if (cmd_rdata_i[bit_idx]) slot_op_o = OP_W1;
    else                    slot_op_o = OP_W0;
  end

  assign slot_req_o  = (state_q == S_SLOT);
  assign slot_od_o   = od_q && ((phase_q == PH_XW) || (phase_q == PH_XR));
  assign cmd_sel_o   = (phase_q == PH_XW);
  assign cmd_raddr_o = AW'(cnt_q >> 3);
  assign rx_sel_o    = (phase_q == PH_XR);
  assign rx_waddr_o  = AW'(cnt_q >> 3);
  assign rx_wdata_o  = sh_nxt;
  assign rx_we_o     = hs && is_rd && ((bit_idx == 3'd7) || last);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign status_o    = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_RST;
      cnt_q    <= '0;
      tries_q  <= '0;
      od_q     <= 1'b0;
      sh_q     <= '0;
      n_romw_q <= '0;
      n_romr_q <= '0;
      n_xw_q   <= '0;
      n_xr_q   <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_SLOT;
          phase_q  <= PH_RST;
          cnt_q    <= '0;
          tries_q  <= '0;
          sh_q     <= '0;
          od_q     <= overdrive_i;
          n_romw_q <= to_slots(clamp_len(rom_len_i, BUF_BYTES));
          n_romr_q <= to_slots(clamp_len(rom_rd_len_i, BUF_BYTES));
          n_xw_q   <= to_slots(clamp_len(xpt_len_i, BUF_BYTES));
          if (xpt_len_i == '0)  n_xr_q <= '0;
          else if (bit_read_i)  n_xr_q <= clamp_len(xpt_rd_len_i, MAXBITS);
          else                  n_xr_q <= to_slots(clamp_len(xpt_rd_len_i, BUF_BYTES));
        end
        S_SLOT: if (slot_done_i) begin
          if (phase_q == PH_RST) begin
            if (slot_pres_i == PR_OK) begin
              if (nxt_any) begin
                phase_q <= nxt_ph;
                cnt_q   <= '0;
              end else begin
                state_q  <= S_FIN;
                status_q <= ST_OK;
              end
            end else if (slot_pres_i == PR_NONE) begin
              if (int'(tries_q) >= RETRIES) begin
                state_q  <= S_FIN;
                status_q <= ST_NODEV;
              end else begin
                tries_q <= tries_q + 1'b1;
              end
            end else begin
              state_q  <= S_FIN;
              status_q <= ST_FAULT;
            end
          end else begin
            if (is_rd) sh_q <= rx_we_o ? 8'h00 : sh_nxt;
            if (last) begin
              cnt_q <= '0;
              if (nxt_any) begin
                phase_q <= nxt_ph;
              end else begin
                state_q  <= S_FIN;
                status_q <= ST_OK;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic unused_wr;
  assign unused_wr = is_wr;
endmodule

// File: rtl/owt_txn_seq.sv
module owt_txn_seq
  import owt_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 8,
  parameter int RETRIES   = 4,
  parameter int AW        = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] rom_len_i,
  input  logic [LEN_W-1:0] rom_rd_len_i,
  input  logic [LEN_W-1:0] xpt_len_i,
  input  logic [LEN_W-1:0] xpt_rd_len_i,
  input  logic             overdrive_i,
  input  logic             bit_read_i,
  input  logic             cmd_we_i,
  input  logic             cmd_sel_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             rsp_sel_i,
  input  logic [AW-1:0]    rsp_addr_i,
  output logic [7:0]       rsp_data_o,
  output logic             slot_req_o,
  output logic [1:0]       slot_op_o,
  output logic             slot_od_o,
  input  logic             slot_done_i,
  input  logic             slot_bit_i,
  input  logic [1:0]       slot_pres_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  logic          cmd_rsel;
  logic [AW-1:0] cmd_raddr;
  logic [7:0]    cmd_rd [2];
  logic [7:0]    rx_rd  [2];
  logic          rx_we, rx_sel;
  logic [AW-1:0] rx_waddr;
  logic [7:0]    rx_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    owt_byte_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_cmd (
      .clk_i   (clk_i),
      .we_i    (cmd_we_i && (cmd_sel_i == 1'(g))),
      .waddr_i (cmd_addr_i),
      .wdata_i (cmd_data_i),
      .raddr_i (cmd_raddr),
      .rdata_o (cmd_rd[g])
    );
    owt_byte_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_rx (
      .clk_i   (clk_i),
      .we_i    (rx_we && (rx_sel == 1'(g))),
      .waddr_i (rx_waddr),
      .wdata_i (rx_wdata),
      .raddr_i (rsp_addr_i),
      .rdata_o (rx_rd[g])
    );
  end

  assign rsp_data_o = rx_rd[rsp_sel_i];

  owt_seq_ctl #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .RETRIES(RETRIES), .AW(AW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .rom_len_i    (rom_len_i),
    .rom_rd_len_i (rom_rd_len_i),
    .xpt_len_i    (xpt_len_i),
    .xpt_rd_len_i (xpt_rd_len_i),
    .overdrive_i  (overdrive_i),
    .bit_read_i   (bit_read_i),
    .cmd_sel_o    (cmd_rsel),
    .cmd_raddr_o  (cmd_raddr),
    .cmd_rdata_i  (cmd_rd[cmd_rsel]),
    .rx_we_o      (rx_we),
    .rx_sel_o     (rx_sel),
    .rx_waddr_o   (rx_waddr),
    .rx_wdata_o   (rx_wdata),
    .slot_req_o   (slot_req_o),
    .slot_op_o    (slot_op_o),
    .slot_od_o    (slot_od_o),
    .slot_done_i  (slot_done_i),
    .slot_bit_i   (slot_bit_i),
    .slot_pres_i  (slot_pres_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .status_o     (status_o)
  );
endmodule

// File: rtl/owt_txn_seq_chk.sv
module owt_txn_seq_chk
  import owt_pkg::*;
#(
  parameter int RETRIES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       slot_req_o,
  input logic [1:0] slot_op_o,
  input logic       slot_od_o,
  input logic       slot_done_i,
  input logic [1:0] slot_pres_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  logic [7:0] rst_hs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_hs_cnt <= '0;
    else if (start_i && !busy_o) rst_hs_cnt <= '0;
    else if (slot_req_o && slot_done_i && slot_op_o == OP_RST && rst_hs_cnt != 8'hff)
      rst_hs_cnt <= rst_hs_cnt + 1'b1;
  end

  p_nodev_tries_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == ST_NODEV |-> rst_hs_cnt == 8'(RETRIES + 1));

  p_fault_abort_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o && slot_done_i && slot_op_o == OP_RST && slot_pres_i[1]
    |=> done_o && status_o == ST_FAULT && !slot_req_o);

  p_reset_regular_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o && slot_op_o == OP_RST |-> !slot_od_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !slot_req_o && !done_o);

  p_req_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o && !slot_done_i |=> slot_req_o && $stable(slot_op_o) && $stable(slot_od_o));
endmodule

bind owt_txn_seq owt_txn_seq_chk #(.RETRIES(RETRIES)) u_chk (.*);

// File: tb/owt_txn_seq_bench.sv
module owt_txn_seq_bench;
  import owt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BUF        = 8;
  localparam int SLAVE_DLY  = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] rom_len_i = '0, rom_rd_len_i = '0, xpt_len_i = '0, xpt_rd_len_i = '0;
  logic       overdrive_i = 1'b0, bit_read_i = 1'b0;
  logic       cmd_we_i = 1'b0, cmd_sel_i = 1'b0;
  logic [2:0] cmd_addr_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic       rsp_sel_i = 1'b0;
  logic [2:0] rsp_addr_i = '0;
  logic [7:0] rsp_data_o;
  logic       slot_req_o, slot_od_o;
  logic [1:0] slot_op_o;
  logic       slot_done_i = 1'b0, slot_bit_i = 1'b0;
  logic [1:0] slot_pres_i = '0;
  logic       busy_o, done_o;
  logic [1:0] status_o;

  owt_txn_seq u_owt_txn_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .rom_len_i(rom_len_i), .rom_rd_len_i(rom_rd_len_i),
    .xpt_len_i(xpt_len_i), .xpt_rd_len_i(xpt_rd_len_i),
    .overdrive_i(overdrive_i), .bit_read_i(bit_read_i),
    .cmd_we_i(cmd_we_i), .cmd_sel_i(cmd_sel_i), .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i),
    .rsp_sel_i(rsp_sel_i), .rsp_addr_i(rsp_addr_i), .rsp_data_o(rsp_data_o),
    .slot_req_o(slot_req_o), .slot_op_o(slot_op_o), .slot_od_o(slot_od_o),
    .slot_done_i(slot_done_i), .slot_bit_i(slot_bit_i), .slot_pres_i(slot_pres_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus model state
  logic [7:0]   rom_cmd [BUF];
  logic [7:0]   xpt_cmd [BUF];
  int           pres_list [$];
  int           pres_ptr;
  logic [255:0] rd_bits;
  int           rd_ptr;
  logic [2:0]   exp_q [$];
  int           dly = 0;
  logic [2:0]   first_seen;

  always @(negedge clk) begin
    if (slot_done_i) begin
      slot_done_i = 1'b0;
      dly = 0;
    end else if (slot_req_o) begin
      if (dly == 0) first_seen = {slot_od_o, slot_op_o};
      if (dly == SLAVE_DLY) begin
        check({slot_od_o, slot_op_o} == first_seen, "R12 slot request held stable",
              int'({slot_od_o, slot_op_o}), int'(first_seen));
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected slot", int'({slot_od_o, slot_op_o}), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check({slot_od_o, slot_op_o} == e, "R3/R5/R6 slot speed+opcode",
                int'({slot_od_o, slot_op_o}), int'(e));
        end
        if (slot_op_o == OP_RST) begin
          slot_pres_i = (pres_ptr < pres_list.size()) ? 2'(pres_list[pres_ptr]) : PR_OK;
          pres_ptr++;
        end
        if (slot_op_o == OP_RD) begin
          slot_bit_i = rd_bits[rd_ptr];
          rd_ptr++;
        end
        slot_done_i = 1'b1;
      end else begin
        dly++;
      end
    end else begin
      dly = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic load_cmd(input bit sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    cmd_we_i = 1'b1; cmd_sel_i = sel; cmd_addr_i = 3'(addr); cmd_data_i = d;
    if (sel) xpt_cmd[addr] = d; else rom_cmd[addr] = d;
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic run_txn(input int rl, input int rrl, input int xl, input int xrl,
                         input bit od, input bit bm, input bit poke, input int exp_st,
                         input string tag);
    int rc, rrc, xc, xbits, e, w, st;
    logic [7:0] exp_rom [BUF];
    logic [7:0] exp_x [BUF];
    rd_bits = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    pres_ptr = 0; rd_ptr = 0; exp_q.delete();
    rc  = (rl > BUF) ? BUF : rl;
    rrc = (rrl > BUF) ? BUF : rrl;
    xc  = (xl > BUF) ? BUF : xl;
    if (xl == 0) xbits = 0;
    else if (bm) xbits = (xrl > BUF * 8) ? BUF * 8 : xrl;
    else xbits = ((xrl > BUF) ? BUF : xrl) * 8;
    // reset/presence sequence
    st = ST_OK;
    for (int r = 0; r < 5; r++) begin
      int p;
      p = (r < pres_list.size()) ? pres_list[r] : 0;
      exp_q.push_back({1'b0, OP_RST});
      if (p == 0) begin st = ST_OK; break; end
      if (p >= 2) begin st = ST_FAULT; break; end
      st = ST_NODEV;
    end
    e = 0;
    for (int b = 0; b < BUF; b++) begin exp_rom[b] = '0; exp_x[b] = '0; end
    if (st == ST_OK) begin
      for (int b = 0; b < rc; b++)
        for (int i = 0; i < 8; i++) exp_q.push_back({1'b0, rom_cmd[b][i] ? OP_W1 : OP_W0});
      for (int b = 0; b < rrc; b++)
        for (int i = 0; i < 8; i++) begin
          exp_q.push_back({1'b0, OP_RD});
          exp_rom[b][i] = rd_bits[e]; e++;
        end
      for (int b = 0; b < xc; b++)
        for (int i = 0; i < 8; i++) exp_q.push_back({od, xpt_cmd[b][i] ? OP_W1 : OP_W0});
      for (int i = 0; i < xbits; i++) begin
        exp_q.push_back({od, OP_RD});
        exp_x[i / 8][i % 8] = rd_bits[e]; e++;
      end
    end
    @(negedge clk);
    rom_len_i = 8'(rl); rom_rd_len_i = 8'(rrl); xpt_len_i = 8'(xl); xpt_rd_len_i = 8'(xrl);
    overdrive_i = od; bit_read_i = bm;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    w = 0;
    while (!done_o && w < 5000) begin
      @(negedge clk);
      w++;
      start_i = poke && (w == 20);
    end
    start_i = 1'b0;
    check(w < 5000, {tag, " R9 done reached"}, w, 0);
    check(int'(status_o) == st, {tag, " R9 status"}, int'(status_o), st);
    check(exp_q.size() == 0, {tag, " R3 all slots issued"}, exp_q.size(), 0);
    @(negedge clk);
    check(!done_o && !busy_o, {tag, " R9 single done pulse then idle"},
          int'({done_o, busy_o}), 0);
    if (st == ST_OK) begin
      rsp_sel_i = 1'b0;
      for (int b = 0; b < rrc; b++) begin
        rsp_addr_i = 3'(b); #1;
        check(rsp_data_o == exp_rom[b], {tag, " R4 ROM rx byte"}, int'(rsp_data_o), int'(exp_rom[b]));
      end
      rsp_sel_i = 1'b1;
      for (int b = 0; b < (xbits + 7) / 8; b++) begin
        rsp_addr_i = 3'(b); #1;
        check(rsp_data_o == exp_x[b], {tag, " R4/R8 transport rx byte"}, int'(rsp_data_o), int'(exp_x[b]));
      end
    end
    if (poke) begin
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        check(!busy_o && !slot_req_o, {tag, " R11 start while busy ignored"},
              int'({busy_o, slot_req_o}), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !slot_req_o && status_o == ST_OK, "R9 reset state",
          int'({busy_o, done_o, slot_req_o, status_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < BUF; a++) begin
      load_cmd(1'b0, a, 8'($urandom));
      load_cmd(1'b1, a, 8'($urandom));
    end
    load_cmd(1'b0, 0, 8'hA5);
    load_cmd(1'b0, 1, 8'h3C);
    load_cmd(1'b1, 0, 8'h96);

    pres_list = {};
    run_txn(2, 1, 1, 2, 1'b0, 1'b0, 1'b0, ST_OK, "basic R3 R4 R5");
    run_txn(1, 0, 2, 11, 1'b1, 1'b1, 1'b0, ST_OK, "overdrive bitread R6 R8");
    pres_list = {1, 1, 1, 1};
    run_txn(1, 1, 0, 0, 1'b0, 1'b0, 1'b0, ST_OK, "retry recovers R1");
    pres_list = {1, 1, 1, 1, 1};
    run_txn(2, 1, 1, 1, 1'b0, 1'b0, 1'b0, ST_NODEV, "no device R1");
    pres_list = {1, 2};
    run_txn(2, 1, 1, 1, 1'b1, 1'b0, 1'b0, ST_FAULT, "wiring fault R2");
    pres_list = {3};
    run_txn(1, 0, 0, 0, 1'b0, 1'b0, 1'b0, ST_FAULT, "fault code 3 R2");
    pres_list = {};
    run_txn(1, 1, 0, 3, 1'b1, 1'b0, 1'b0, ST_OK, "no transport R7");
    run_txn(200, 9, 20, 200, 1'b1, 1'b1, 1'b0, ST_OK, "clamp R10");
    run_txn(0, 0, 3, 9, 1'b0, 1'b0, 1'b0, ST_OK, "clamp bytes R10");
    run_txn(2, 1, 1, 2, 1'b0, 1'b0, 1'b1, ST_OK, "busy start R11");
    run_txn(0, 0, 0, 0, 1'b1, 1'b1, 1'b0, ST_OK, "empty R9");
    run_txn(0, 0, 1, 8, 1'b0, 1'b1, 1'b0, ST_OK, "bitread full byte R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule